// File: doc/BRIEF.md
# Ring Insertion and Removal Scrub Controller

This block governs how a station joins and leaves a token ring. It keeps one of four states: out of the ring, scrubbing on the way in, scrubbing on the way out, and in the ring. Each move into or out of the ring passes through a scrub interval. During that interval the transmit path carries only constant Idle symbol pairs, so that fragments circulating on the ring are removed before the topology changes. A programmable scrub time sets the length of the interval. The controller loads that value into a down-counter when a scrub interval begins.

If the connection breaks during an insertion scrub, the interval does not stop early. It runs for its full length and then ends in the out-of-ring state instead of the in-ring state. A processor scrub request combined with the connection sequencer reporting maintenance also forces Idle onto the output. In every other case the bypass path data passes straight through. The output stage is registered, so it reflects the state and inputs present at the clock edge that loads it.

Top module: `ring_scrub_ctrl`

## Requirements
- R1: While `rst` is high, each clock edge sets `state_code` to 2'b00 and `tx_data` to the Idle pair (all ones).
- R2: `state_code` uses this encoding: 2'b00 out of ring, 2'b01 insertion scrub, 2'b10 removal scrub, 2'b11 in ring.
- R3: In the out-of-ring state, `insert_req` moves the state to insertion scrub at the next edge. In that state `remove_req` and `conn_break` have no effect.
- R4: A scrub state stays visible for exactly `scrub_time`+1 clock cycles. `scrub_time` is sampled only at the edge that enters the scrub state, and later changes to it have no effect on the interval already running.
- R5: An insertion scrub that sees neither `conn_break` nor `remove_req` in any of its cycles ends in the in-ring state.
- R6: If `conn_break` or `remove_req` is high in any cycle of an insertion scrub, including its last cycle, the scrub still runs its full length and then ends in the out-of-ring state.
- R7: In the in-ring state, `remove_req` or `conn_break` moves the state to removal scrub. When the removal scrub expires, the state returns to out of ring.
- R8: After an edge at which the state was insertion scrub or removal scrub, `tx_data` equals the Idle pair.
- R9: After an edge at which `scrub_req` and `seq_maint` were both high, `tx_data` equals the Idle pair. Either of these inputs alone does not force Idle.
- R10: After an edge that meets neither R8 nor R9, `tx_data` equals the value `bypass_data` had at that edge.
- R11: `insert_req` has no effect in the insertion scrub, removal scrub and in-ring states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insert_req | input | 1 | Request to join the ring |
| remove_req | input | 1 | Request to leave the ring |
| conn_break | input | 1 | Connection to the neighbour has broken |
| scrub_req | input | 1 | Processor request to scrub |
| seq_maint | input | 1 | Connection sequencer is in maintenance |
| scrub_time | input | TIME_W (16) | Scrub interval length minus one, in clock cycles |
| bypass_data | input | 2*SYM_W (10) | Symbol pair from the bypass path |
| tx_data | output | 2*SYM_W (10) | Registered output symbol pair |
| state_code | output | 2 | Current state, encoded as in R2 |

## Verification
The assertions assume that every request input is synchronous to `clk` and holds a defined value at every edge after reset. They also assume that `scrub_time` is stable at the edge that starts a scrub. The interval check latches `scrub_time` on that edge, so it tolerates later changes. The stimulus changes inputs only at falling edges and holds them across the following rising edge. It uses short scrub times, including zero, so every interval finishes within a handful of cycles.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  typedef enum logic [1:0] {
    ST_OUT      = 2'b00,
    ST_IN_SCRUB = 2'b01,
    ST_RM_SCRUB = 2'b10,
    ST_IN_RING  = 2'b11
  } ring_st_e;

  function automatic logic is_scrub(input ring_st_e s);
    return (s == ST_IN_SCRUB) || (s == ST_RM_SCRUB);
  endfunction

endpackage

// File: rtl/scrub_timer.sv
module scrub_timer #(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  input  logic              run,
  output logic              expired
);
  logic [TIME_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)
      remain <= '0;
    else if (load)
      remain <= load_val;
    else if (run && (remain != '0))
      remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/scrub_fsm.sv
module scrub_fsm
  import scrub_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     insert_req,
  input  logic     remove_req,
  input  logic     conn_break,
  input  logic     expired,
  output ring_st_e state,
  output logic     load
);
  ring_st_e nxt;
  logic     abort_q;
  logic     leave_now;

  assign leave_now = remove_req | conn_break;

  always_comb begin
    nxt  = state;
    load = 1'b0;
    unique case (state)
      ST_OUT: begin
        if (insert_req) begin
          nxt  = ST_IN_SCRUB;
          load = 1'b1;
        end
      end
      ST_IN_SCRUB: begin
        if (expired)
          nxt = (abort_q || leave_now) ? ST_OUT : ST_IN_RING;
      end
      ST_IN_RING: begin
        if (leave_now) begin
          nxt  = ST_RM_SCRUB;
          load = 1'b1;
        end
      end
      ST_RM_SCRUB: begin
        if (expired)
          nxt = ST_OUT;
      end
      default: nxt = ST_OUT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_OUT;
      abort_q <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_OUT)
        abort_q <= 1'b0;
      else if (state == ST_IN_SCRUB && leave_now)
        abort_q <= 1'b1;
    end
  end
endmodule

// File: rtl/idle_mux.sv
module idle_mux #(
  parameter int              DATA_W = 10,
  parameter logic [DATA_W-1:0] IDLE_PAIR = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              force_idle,
  input  logic [DATA_W-1:0] bypass,
  output logic [DATA_W-1:0] tx
);
  always_ff @(posedge clk) begin
    if (rst)
      tx <= IDLE_PAIR;
    else if (force_idle)
      tx <= IDLE_PAIR;
    else
      tx <= bypass;
  end
endmodule

// File: rtl/ring_scrub_ctrl.sv
module ring_scrub_ctrl
  import scrub_pkg::*;
#(
  parameter int              SYM_W    = 5,
  parameter int              TIME_W   = 16,
  parameter logic [SYM_W-1:0] IDLE_SYM = '1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 insert_req,
  input  logic                 remove_req,
  input  logic                 conn_break,
  input  logic                 scrub_req,
  input  logic                 seq_maint,
  input  logic [TIME_W-1:0]    scrub_time,
  input  logic [2*SYM_W-1:0]   bypass_data,
  output logic [2*SYM_W-1:0]   tx_data,
  output logic [1:0]           state_code
);
  localparam int                DATA_W    = 2 * SYM_W;
  localparam logic [DATA_W-1:0] IDLE_PAIR = {2{IDLE_SYM}};

  ring_st_e state;
  logic     load;
  logic     expired;
  logic     force_idle;

  scrub_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .insert_req (insert_req),
    .remove_req (remove_req),
    .conn_break (conn_break),
    .expired    (expired),
    .state      (state),
    .load       (load)
  );

  scrub_timer #(.TIME_W(TIME_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (scrub_time),
    .run      (is_scrub(state)),
    .expired  (expired)
  );

  assign force_idle = is_scrub(state) | (scrub_req & seq_maint);

  idle_mux #(.DATA_W(DATA_W), .IDLE_PAIR(IDLE_PAIR)) u_mux (
    .clk        (clk),
    .rst        (rst),
    .force_idle (force_idle),
    .bypass     (bypass_data),
    .tx         (tx_data)
  );

  assign state_code = state;
endmodule

// File: rtl/ring_scrub_ctrl_chk.sv
module ring_scrub_ctrl_chk #(
  parameter int DATA_W = 10,
  parameter int TIME_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              insert_req,
  input logic              remove_req,
  input logic              conn_break,
  input logic              scrub_req,
  input logic              seq_maint,
  input logic [TIME_W-1:0] scrub_time,
  input logic [DATA_W-1:0] bypass_data,
  input logic [DATA_W-1:0] tx_data,
  input logic [1:0]        state_code
);
  logic              in_scrub;
  logic [TIME_W:0]   run_len;
  logic [TIME_W-1:0] lim;

  assign in_scrub = (state_code == 2'b01) || (state_code == 2'b10);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= '0;
      lim     <= '0;
    end else if ((state_code == 2'b00 && insert_req) ||
                 (state_code == 2'b11 && (remove_req || conn_break))) begin
      run_len <= '0;
      lim     <= scrub_time;
    end else if (in_scrub) begin
      run_len <= run_len + 1'b1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (state_code == 2'b00 && tx_data == '1));

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'b00 && !insert_req) |=> state_code == 2'b00);

  // R4
  scrub_len_chk: assert property (@(posedge clk) disable iff (rst)
    in_scrub |-> (run_len <= {1'b0, lim}));

  // R4
  scrub_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (in_scrub && run_len == {1'b0, lim}) |=> !in_scrub);

  // R7
  ring_leave_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 2'b11 |=> (state_code == 2'b11 || state_code == 2'b10));

  // R7
  rm_scrub_dest_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 2'b10 |=> (state_code == 2'b10 || state_code == 2'b00));

  // R8
  scrub_idle_chk: assert property (@(posedge clk) disable iff (rst)
    in_scrub |=> tx_data == '1);

  // R9
  maint_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (scrub_req && seq_maint) |=> tx_data == '1);

  // R10
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_scrub && !(scrub_req && seq_maint)) |=> tx_data == $past(bypass_data));
endmodule

bind ring_scrub_ctrl ring_scrub_ctrl_chk #(.DATA_W(2*SYM_W), .TIME_W(TIME_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .insert_req  (insert_req),
  .remove_req  (remove_req),
  .conn_break  (conn_break),
  .scrub_req   (scrub_req),
  .seq_maint   (seq_maint),
  .scrub_time  (scrub_time),
  .bypass_data (bypass_data),
  .tx_data     (tx_data),
  .state_code  (state_code)
);

// File: tb/sim_ring_scrub_ctrl.sv
`timescale 1ns/1ps
module sim_ring_scrub_ctrl;
  localparam int          SYM_W  = 5;
  localparam int          TIME_W = 16;
  localparam int          DW     = 2 * SYM_W;
  localparam logic [DW-1:0] IDLE = '1;
  localparam int          NV     = 28;

  // each entry: insert, remove, break, scrub_req, maint, expected state[1:0]
  localparam logic [6:0] VEC [NV] = '{
    7'b00000_00, 7'b10000_01, 7'b00000_01, 7'b00000_01,
    7'b00000_11, 7'b00010_11, 7'b00011_11, 7'b00000_11,
    7'b01000_10, 7'b00000_10, 7'b00000_10, 7'b00000_00,
    7'b10000_01, 7'b00100_01, 7'b00000_01, 7'b00000_00,
    7'b01000_00, 7'b00100_00, 7'b10000_01, 7'b10000_01,
    7'b00000_01, 7'b00000_11, 7'b00100_10, 7'b00000_10,
    7'b00000_10, 7'b00000_00, 7'b00001_00, 7'b00011_00
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic insert_req = 1'b0, remove_req = 1'b0, conn_break = 1'b0;
  logic scrub_req = 1'b0, seq_maint = 1'b0;
  logic [TIME_W-1:0] scrub_time = '0;
  logic [DW-1:0] bypass_data = '0;
  logic [DW-1:0] tx_data;
  logic [1:0]    state_code;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ring_scrub_ctrl #(.SYM_W(SYM_W), .TIME_W(TIME_W)) u0 (
    .clk(clk), .rst(rst), .insert_req(insert_req), .remove_req(remove_req),
    .conn_break(conn_break), .scrub_req(scrub_req), .seq_maint(seq_maint),
    .scrub_time(scrub_time), .bypass_data(bypass_data),
    .tx_data(tx_data), .state_code(state_code)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic i, input logic r, input logic b,
                       input logic s, input logic m);
    insert_req = i; remove_req = r; conn_break = b; scrub_req = s; seq_maint = m;
  endtask

  task automatic step_state(input string req, input logic [1:0] exp);
    @(negedge clk);
    chk(req, DW'(state_code), DW'(exp));
  endtask

  initial begin
    logic [1:0] prev_st;
    logic [DW-1:0] exp_tx;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 state", DW'(state_code), '0);
    chk("R1 tx", tx_data, IDLE);
    rst = 1'b0;
    scrub_time = 16'd2;
    prev_st = 2'b00;

    // table walk: R2 R3 R5 R6 R7 R8 R9 R10 R11
    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][6], VEC[k][5], VEC[k][4], VEC[k][3], VEC[k][2]);
      bypass_data = DW'(10'h0A5 ^ (k * 37));
      exp_tx = ((prev_st == 2'b01) || (prev_st == 2'b10) || (VEC[k][3] && VEC[k][2]))
               ? IDLE : bypass_data;
      @(negedge clk);
      chk($sformatf("R2 table state %0d", k), DW'(state_code), DW'(VEC[k][1:0]));
      chk($sformatf("R8/R9/R10 table tx %0d", k), tx_data, exp_tx);
      prev_st = VEC[k][1:0];
    end

    // R4 zero scrub time: one cycle of scrub
    drive(0, 0, 0, 0, 0);
    scrub_time = 16'd0;
    drive(1, 0, 0, 0, 0); step_state("R4 zero entry", 2'b01);
    drive(0, 0, 0, 0, 0); step_state("R4 zero expire", 2'b11);
    drive(0, 1, 0, 0, 0); step_state("R7 zero rm", 2'b10);
    drive(0, 0, 0, 0, 0); step_state("R7 zero back", 2'b00);

    // R4 time sampled only at entry
    scrub_time = 16'd1;
    drive(1, 0, 0, 0, 0); step_state("R4 latch entry", 2'b01);
    scrub_time = 16'd6;
    drive(0, 0, 0, 0, 0); step_state("R4 latch hold", 2'b01);
    step_state("R4 latch expire", 2'b11);

    // R7 removal scrub then reset mid-scrub (R1)
    drive(0, 1, 0, 0, 0); step_state("R7 rm entry", 2'b10);
    drive(0, 0, 0, 0, 0);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-scrub state", DW'(state_code), '0);
    chk("R1 mid-scrub tx", tx_data, IDLE);
    rst = 1'b0;

    // R6 remove_req during insertion scrub
    scrub_time = 16'd1;
    drive(1, 0, 0, 0, 0); step_state("R6 rm entry", 2'b01);
    drive(0, 1, 0, 0, 0); step_state("R6 rm hold", 2'b01);
    drive(0, 0, 0, 0, 0); step_state("R6 rm end out", 2'b00);

    // R6 break on the final scrub cycle
    drive(1, 0, 0, 0, 0); step_state("R6 late entry", 2'b01);
    drive(0, 0, 0, 0, 0); step_state("R6 late hold", 2'b01);
    drive(0, 0, 1, 0, 0); step_state("R6 late end out", 2'b00);
    drive(0, 0, 0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule